// File: doc/BRIEF.md
# Iterative Shift-and-Add Multiplier

This block multiplies two unsigned operands over several clock cycles, using one adder and no multiplier array. A start request latches the multiplicand into a left-shifting register, zero-extended to the product width. It latches the multiplier into a right-shifting register and clears the product register in the same cycle. The block then shifts both registers by one bit each cycle. Whenever the multiplier's lowest bit is one, it adds the current shifted multiplicand into the product.

The run stops as soon as the multiplier register holds no set bits, so small multipliers finish early. A done flag then rises, and the product stays on its port until the next start. A caller pulses start in the idle state and waits for done. If start is still high when the result arrives, done stays high until start is released.

Top module: `iter_mult`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle, and after that edge done and prod both read 0.
- R2: A start sampled high in idle loads both operands and clears prod. One edge later, prod reads 0 even if it held an earlier result.
- R3: When done rises, prod equals op_a × op_b as unsigned numbers, for every operand pair (prod is NA+NB bits wide).
- R4: Count the start edge as edge 0, and let k be the index of the highest set bit of op_b plus one (k = 0 when op_b is 0). Done is first seen high after edge k+1.
- R5: Done is high for exactly one cycle when start is low at the edge where done is showing. While start stays high, done stays high.
- R6: After done, prod keeps its value until the next accepted start.
- R7: While a multiplication runs, start pulses and changes on op_a/op_b have no effect on its result or on its timing.
- R8: In idle with start low, changes on op_a/op_b leave prod unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin request, also holds done while high |
| op_a | input | NA | Multiplicand, unsigned |
| op_b | input | NB | Multiplier, unsigned |
| prod | output | NA+NB | Product register |
| done | output | 1 | Result-ready flag |

## Verification
Two things can happen in the same edge: an addition into the product and a left shift of the multiplicand that feeds it. The sum must use the value from before the shift. Every one of the 256 operand pairs is run, so each multiplier bit pattern makes additions coincide with shifts at every bit position. A wrong ordering would scale the partial products and break the exact comparison with op_a × op_b. The end of the run is also judged: the zero test on the multiplier must stop the run on the cycle after its last shift, and the bench checks this against the latency it computes from the top set bit of op_b.

// File: rtl/imul_pkg.sv
// Shared types for the iterative multiplier.
// Assumes: three control states, encoded in two bits.
package imul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } imul_state_e;
endpackage

// File: rtl/imul_shreg.sv
// Loadable shift register whose direction is chosen by a parameter.
// Assumes: load takes priority over shift; nothing changes while en is low.
module imul_shreg #(
    parameter int W          = 8,
    parameter bit SHIFT_LEFT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] shifted;

    // Selects the shift direction at elaboration.
    generate
        if (SHIFT_LEFT) begin : g_left
            assign shifted = {q[W-2:0], 1'b0};
        end else begin : g_right
            assign shifted = {1'b0, q[W-1:1]};
        end
    endgenerate

    // Register update: reset, then load, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (en) begin
            if (load)     q <= d;
            else          q <= shifted;
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> (q == $past(d)));
endmodule

// File: rtl/imul_acc.sv
// Product accumulator with a synchronous clear and an enable.
// Assumes: the caller sizes W so that the sum never overflows.
module imul_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic [W-1:0] addend,
    output logic [W-1:0] q
);
    // Accumulate or clear when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= '0;
        else if (en) begin
            if (clr)         q <= '0;
            else             q <= q + addend;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
endmodule

// File: rtl/imul_ctrl.sv
// Three-state sequencer: idle, running, result ready.
// Assumes: zero reports an all-zero multiplier register.
module imul_ctrl
    import imul_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        zero,
    output logic        load_en,
    output logic        run_en,
    output logic        done,
    output imul_state_e state
);
    imul_state_e nxt;

    // Next-state choice.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_RUN;
            ST_RUN:  if (zero)  nxt = ST_DONE;
            ST_DONE: if (!start) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Moore and Mealy control outputs.
    assign load_en = (state == ST_IDLE) && start;
    assign run_en  = (state == ST_RUN) && !zero;
    assign done    = (state == ST_DONE);

    p_done_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done);
    p_ends_on_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && zero) |=> done);
endmodule

// File: rtl/iter_mult.sv
// Unsigned shift-and-add multiplier that stops early when the multiplier empties.
// Assumes: operands are sampled only on an accepted start.
module iter_mult
    import imul_pkg::*;
#(
    parameter int NA = 4,
    parameter int NB = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NA-1:0]      op_a,
    input  logic [NB-1:0]      op_b,
    output logic [NA+NB-1:0]   prod,
    output logic               done
);
    localparam int PW = NA + NB;

    logic        load_en, run_en, b_zero;
    logic [PW-1:0] a_q;
    logic [NB-1:0] b_q;
    imul_state_e   state;

    assign b_zero = (b_q == '0);

    imul_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .zero(b_zero),
        .load_en(load_en), .run_en(run_en), .done(done), .state(state)
    );

    imul_shreg #(.W(PW), .SHIFT_LEFT(1'b1)) u_a (
        .clk(clk), .rst_n(rst_n), .en(load_en | run_en), .load(load_en),
        .d({{NB{1'b0}}, op_a}), .q(a_q)
    );

    imul_shreg #(.W(NB), .SHIFT_LEFT(1'b0)) u_b (
        .clk(clk), .rst_n(rst_n), .en(load_en | run_en), .load(load_en),
        .d(op_b), .q(b_q)
    );

    imul_acc #(.W(PW)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(load_en | (run_en & b_q[0])),
        .clr(load_en), .addend(a_q), .q(prod)
    );

    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (prod == '0));
    p_result_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(prod));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(prod));
endmodule

// File: tb/iter_mult_tb_top.sv
module iter_mult_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NA-1:0] op_a = '0;
    logic [NB-1:0] op_b = '0;
    logic [NA+NB-1:0] prod;
    logic done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iter_mult #(.NA(NA), .NB(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .prod(prod), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int top_len(input int b);
        int k = 0;
        for (int i = 0; i < NB; i++) if (b[i]) k = i + 1;
        return k;
    endfunction

    // One multiplication; disturb=1 pokes inputs mid-run, idle_poke=1 pokes after.
    task automatic run_one(input int a, input int b, input bit disturb, input bit idle_poke);
        int n;
        int exp_lat;
        logic [NA+NB-1:0] held;
        exp_lat = top_len(b) + 1;
        @(negedge clk);
        op_a = a[NA-1:0]; op_b = b[NB-1:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(prod == 0, "R2 cleared after start", prod, 0);
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (disturb && n == 1 && !done) begin
                op_a = ~a[NA-1:0]; op_b = ~b[NB-1:0]; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(n == exp_lat, "R4 latency (R7 when disturbed)", n, exp_lat);
        chk(prod == a * b, "R3 product (R7 when disturbed)", prod, a * b);
        held = prod;
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
        chk(prod == held, "R6 product held", prod, held);
        if (idle_poke) begin
            op_a = ~op_a; op_b = ~op_b;
            @(negedge clk);
            @(negedge clk);
            chk(prod == held, "R8 idle input change", prod, held);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(prod == 0, "R1 prod after reset", prod, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_one(a, b, (a + b) % 3 == 0, (a ^ b) % 5 == 0);
        // R5: start held through the whole run keeps done high.
        @(negedge clk);
        op_a = 4'd9; op_b = 4'd10; start = 1'b1;
        repeat (8) @(negedge clk);
        chk(done == 1'b1, "R5 done held by start", done, 1);
        chk(prod == 8'h5A, "R3 9x10", prod, 8'h5A);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R5 done released", done, 0);
        // R1: reset mid-run.
        start = 1'b1; op_a = 4'hF; op_b = 4'hF;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(prod == 0 && done == 0, "R1 reset mid-run", prod, 0);
        rst_n = 1'b1;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule